// File: doc/BRIEF.md
# SCSI Bus Event Status Register

This block collects bus events reported by a SCSI controller's phase logic and holds them as sticky status bits for a host to read. It handles six event sources: being selected, being reselected, a target dropping off the bus, a selection timeout, the bus reset line, and the parity result of each received byte. Each event is recorded only when the control inputs allow it. These controls are the two response enables, the match of the incoming ID against the device's own response ID, the operating mode, and the parity-check enable.

The host reads the status vector and sends a read strobe, which clears all bits together. A masked OR of the bits drives one interrupt request line. The block also produces odd parity for outgoing data bytes, so the transmit and receive sides use the same parity convention.

Top module: `scsi_evt_status`

## Requirements
- R1: Status bit 0 (selected) sets one cycle after `sel_det` is high, but only when `sel_resp_en` is 1 and `sel_id` equals `own_id`. Otherwise that selection has no effect.
- R2: Status bit 1 (reselected) sets one cycle after `resel_det` is high, but only when `resel_resp_en` is 1 and `resel_id` equals `own_id`. Otherwise that reselection has no effect.
- R3: Status bit 2 (unexpected disconnect) is set by `disc_det` in initiator mode (`mode`=0) only when `disc_expected` is 0. In target mode (`mode`=1) and in the reserved code `mode`=3, disconnects are ignored.
- R4: In low-level mode (`mode`=2), every `disc_det` sets bit 2, including one with `disc_expected`=1.
- R5: A `sel_timeout` pulse sets bit 2 in any mode, one cycle later.
- R6: Bit 3 (bus reset) is set only by a rising edge of `bus_rst`, whether the reset was driven from outside or by the device itself. A level held for many cycles gives one event. A level that is already high when `rst_n` is released counts as a rising edge.
- R7: Bit 4 (parity error) sets when `rx_valid` is 1, `par_chk_en` is 1, and the 9 bits `{rx_data, rx_par}` have an even count of ones. Every other received byte leaves bit 4 unchanged.
- R8: Status bits stay set until `rd_clr` is high, which clears all of them on the next edge. An event in the same cycle as `rd_clr` stays set. Reset clears every bit and drives `irq` to 0.
- R9: `irq` is high exactly when some status bit and the `int_mask` bit at the same position are both 1. It follows the mask with no clock delay.
- R10: `tx_par` always gives `{tx_data, tx_par}` an odd count of ones. This does not depend on `par_chk_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_det | input | 1 | Selection by another device detected (pulse) |
| sel_id | input | ID_W | ID targeted by the selection |
| sel_resp_en | input | 1 | Enable response to selection |
| resel_det | input | 1 | Reselection detected (pulse) |
| resel_id | input | ID_W | ID targeted by the reselection |
| resel_resp_en | input | 1 | Enable response to reselection |
| own_id | input | ID_W | Own response ID |
| mode | input | 2 | 0 initiator, 1 target, 2 low-level, 3 reserved (acts as target) |
| disc_det | input | 1 | Target left the bus (pulse) |
| disc_expected | input | 1 | The disconnect was an expected one |
| sel_timeout | input | 1 | Selection timeout (pulse) |
| bus_rst | input | 1 | Detected bus reset line level |
| rx_valid | input | 1 | A received data byte is present |
| rx_data | input | 8 | Received data byte |
| rx_par | input | 1 | Received parity bit |
| par_chk_en | input | 1 | Enable receive parity checking |
| tx_data | input | 8 | Outgoing data byte |
| tx_par | output | 1 | Generated odd parity for tx_data |
| rd_clr | input | 1 | Host read strobe, clears status |
| int_mask | input | 5 | Per-bit interrupt enable |
| status | output | 5 | Sticky event bits: 0 sel, 1 resel, 2 disconnect, 3 bus reset, 4 parity |
| irq | output | 1 | Masked OR of status |

## Verification
The hardest case to reach is a bus reset level that stays high across a host clear. The bit must stay clear afterwards, which shows that no second event was raised by the same assertion. The stimulus sets the bit, clears it while the line is still high, and holds the line for several cycles. It then releases and raises the line again to show that a new edge is recorded. The stimulus table also sends every event together with a clear strobe, so that each vector shows both the event qualification and the rule that a same-cycle event stays set.

// File: rtl/scsi_evt_pkg.sv
`timescale 1ns/1ps
package scsi_evt_pkg;
    localparam int NUM_EVT = 5;
    localparam int B_SEL   = 0;
    localparam int B_RESEL = 1;
    localparam int B_UDC   = 2;
    localparam int B_BRST  = 3;
    localparam int B_PAR   = 4;

    typedef enum logic [1:0] {
        MODE_INIT = 2'd0,
        MODE_TGT  = 2'd1,
        MODE_LOW  = 2'd2,
        MODE_RSVD = 2'd3
    } mode_e;
endpackage

// File: rtl/scsi_evt_qual.sv
`timescale 1ns/1ps
module scsi_evt_qual
    import scsi_evt_pkg::*;
#(
    parameter int ID_W = 3
) (
    input  logic            sel_det,
    input  logic [ID_W-1:0] sel_id,
    input  logic            sel_resp_en,
    input  logic            resel_det,
    input  logic [ID_W-1:0] resel_id,
    input  logic            resel_resp_en,
    input  logic [ID_W-1:0] own_id,
    input  mode_e           mode,
    input  logic            disc_det,
    input  logic            disc_expected,
    input  logic            sel_timeout,
    output logic            sel_evt,
    output logic            resel_evt,
    output logic            udc_evt
);
    logic disc_counts;

    always_comb begin
        sel_evt   = sel_det   && sel_resp_en   && (sel_id   == own_id);
        resel_evt = resel_det && resel_resp_en && (resel_id == own_id);
        unique case (mode)
            MODE_INIT: disc_counts = !disc_expected;
            MODE_LOW:  disc_counts = 1'b1;
            default:   disc_counts = 1'b0;
        endcase
        udc_evt = (disc_det && disc_counts) || sel_timeout;
    end
endmodule

// File: rtl/scsi_rst_edge.sv
`timescale 1ns/1ps
module scsi_rst_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_rst,
    output logic rise_evt
);
    typedef struct packed {
        logic prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = bus_rst;
        rise_evt  = bus_rst && !st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/scsi_par_unit.sv
`timescale 1ns/1ps
module scsi_par_unit #(
    parameter int DATA_W = 8
) (
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_par,
    input  logic              par_chk_en,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_par,
    output logic              par_evt
);
    logic rx_ones_odd;

    always_comb begin
        rx_ones_odd = ^{rx_data, rx_par};
        par_evt     = rx_valid && par_chk_en && !rx_ones_odd;
        tx_par      = ~(^tx_data);
    end
endmodule

// File: rtl/scsi_evt_status.sv
`timescale 1ns/1ps
module scsi_evt_status
    import scsi_evt_pkg::*;
#(
    parameter int ID_W   = 3,
    parameter int DATA_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_det,
    input  logic [ID_W-1:0]    sel_id,
    input  logic               sel_resp_en,
    input  logic               resel_det,
    input  logic [ID_W-1:0]    resel_id,
    input  logic               resel_resp_en,
    input  logic [ID_W-1:0]    own_id,
    input  logic [1:0]         mode,
    input  logic               disc_det,
    input  logic               disc_expected,
    input  logic               sel_timeout,
    input  logic               bus_rst,
    input  logic               rx_valid,
    input  logic [DATA_W-1:0]  rx_data,
    input  logic               rx_par,
    input  logic               par_chk_en,
    input  logic [DATA_W-1:0]  tx_data,
    output logic               tx_par,
    input  logic               rd_clr,
    input  logic [NUM_EVT-1:0] int_mask,
    output logic [NUM_EVT-1:0] status,
    output logic               irq
);
    typedef struct packed {
        logic [NUM_EVT-1:0] stat;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic sel_evt, resel_evt, udc_evt, brst_evt, par_evt;
    logic [NUM_EVT-1:0] evt_vec;

    scsi_evt_qual #(.ID_W(ID_W)) i_qual (
        .sel_det       (sel_det),
        .sel_id        (sel_id),
        .sel_resp_en   (sel_resp_en),
        .resel_det     (resel_det),
        .resel_id      (resel_id),
        .resel_resp_en (resel_resp_en),
        .own_id        (own_id),
        .mode          (mode_e'(mode)),
        .disc_det      (disc_det),
        .disc_expected (disc_expected),
        .sel_timeout   (sel_timeout),
        .sel_evt       (sel_evt),
        .resel_evt     (resel_evt),
        .udc_evt       (udc_evt)
    );

    scsi_rst_edge i_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_rst  (bus_rst),
        .rise_evt (brst_evt)
    );

    scsi_par_unit #(.DATA_W(DATA_W)) i_par (
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_par     (rx_par),
        .par_chk_en (par_chk_en),
        .tx_data    (tx_data),
        .tx_par     (tx_par),
        .par_evt    (par_evt)
    );

    always_comb begin
        evt_vec          = '0;
        evt_vec[B_SEL]   = sel_evt;
        evt_vec[B_RESEL] = resel_evt;
        evt_vec[B_UDC]   = udc_evt;
        evt_vec[B_BRST]  = brst_evt;
        evt_vec[B_PAR]   = par_evt;

        st_d      = st_q;
        st_d.stat = (rd_clr ? '0 : st_q.stat) | evt_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q.stat;
    assign irq    = |(st_q.stat & int_mask);
endmodule

// File: rtl/scsi_evt_status_chk.sv
`timescale 1ns/1ps
module scsi_evt_status_chk
    import scsi_evt_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sel_det,
    input logic               sel_resp_en,
    input logic               resel_det,
    input logic               resel_resp_en,
    input logic [1:0]         mode,
    input logic               disc_det,
    input logic               sel_timeout,
    input logic               bus_rst,
    input logic               rx_valid,
    input logic               par_chk_en,
    input logic [DATA_W-1:0]  tx_data,
    input logic               tx_par,
    input logic               rd_clr,
    input logic [NUM_EVT-1:0] int_mask,
    input logic [NUM_EVT-1:0] status,
    input logic               irq
);
    AST_SEL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_det && !sel_resp_en && rd_clr) |=> !status[B_SEL]); // R1
    AST_RESEL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (resel_det && !resel_resp_en && rd_clr) |=> !status[B_RESEL]); // R2
    AST_TGT_DISC_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1 && disc_det && !sel_timeout && rd_clr) |=> !status[B_UDC]); // R3
    AST_STO_SETS_UDC: assert property (@(posedge clk) disable iff (!rst_n)
        sel_timeout |=> status[B_UDC]); // R5
    AST_HELD_RST_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && bus_rst && $past(bus_rst)) |=> !status[B_BRST]); // R6
    AST_PAR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!par_chk_en && rd_clr) |=> !status[B_PAR]); // R7
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr |=> ((status & $past(status)) == $past(status))); // R8
    AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !sel_det && !resel_det && !disc_det && !sel_timeout
         && !bus_rst && !rx_valid) |=> (status == '0)); // R8
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & int_mask) == '0) |-> !irq); // R9
    AST_TX_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        (^{tx_data, tx_par}) == 1'b1); // R10
endmodule

bind scsi_evt_status scsi_evt_status_chk #(.DATA_W(DATA_W)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sel_det       (sel_det),
    .sel_resp_en   (sel_resp_en),
    .resel_det     (resel_det),
    .resel_resp_en (resel_resp_en),
    .mode          (mode),
    .disc_det      (disc_det),
    .sel_timeout   (sel_timeout),
    .bus_rst       (bus_rst),
    .rx_valid      (rx_valid),
    .par_chk_en    (par_chk_en),
    .tx_data       (tx_data),
    .tx_par        (tx_par),
    .rd_clr        (rd_clr),
    .int_mask      (int_mask),
    .status        (status),
    .irq           (irq)
);

// File: tb/test_scsi_evt_status.sv
`timescale 1ns/1ps
module test_scsi_evt_status;
    localparam int ID_W = 3;
    localparam int NV   = 15;

    typedef struct packed {
        logic [1:0] mode;
        logic       sel;
        logic       resel;
        logic [2:0] id;
        logic       sel_en;
        logic       resel_en;
        logic       disc;
        logic       disc_exp;
        logic       sto;
        logic       rxv;
        logic [7:0] rxd;
        logic       rxp;
        logic       pchk;
        logic [4:0] exp;
    } vec_t;

    // own_id is 5 for every vector
    localparam vec_t VEC [NV] = '{
        '{2'd0,1'b1,1'b0,3'd5,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,1'b1,1'b0,5'b00001}, // R1 match
        '{2'd0,1'b1,1'b0,3'd5,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,1'b1,1'b0,5'b00000}, // R1 disabled
        '{2'd0,1'b1,1'b0,3'd3,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,1'b1,1'b0,5'b00000}, // R1 wrong id
        '{2'd1,1'b0,1'b1,3'd5,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,8'h00,1'b1,1'b0,5'b00010}, // R2 match
        '{2'd1,1'b0,1'b1,3'd4,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,8'h00,1'b1,1'b0,5'b00000}, // R2 wrong id
        '{2'd1,1'b0,1'b1,3'd5,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,1'b1,1'b0,5'b00000}, // R2 disabled
        '{2'd0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,8'h00,1'b1,1'b0,5'b00100}, // R3 init unexpected
        '{2'd0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,8'h00,1'b1,1'b0,5'b00000}, // R3 init expected
        '{2'd1,1'b0,1'b0,3'd0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,8'h00,1'b1,1'b0,5'b00000}, // R3 target
        '{2'd2,1'b0,1'b0,3'd0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,8'h00,1'b1,1'b0,5'b00100}, // R4 low-level
        '{2'd1,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,8'h00,1'b1,1'b0,5'b00100}, // R5 timeout
        '{2'd0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,8'h00,1'b0,1'b1,5'b10000}, // R7 bad parity
        '{2'd0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,8'h00,1'b1,1'b1,5'b00000}, // R7 good parity
        '{2'd0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,8'h00,1'b0,1'b0,5'b00000}, // R7 check off
        '{2'd0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,8'h01,1'b0,1'b1,5'b00000}  // R7 good, data odd
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_det = 0, sel_resp_en = 0, resel_det = 0, resel_resp_en = 0;
    logic [ID_W-1:0] sel_id = '0, resel_id = '0, own_id = 3'd5;
    logic [1:0] mode = '0;
    logic disc_det = 0, disc_expected = 0, sel_timeout = 0, bus_rst = 0;
    logic rx_valid = 0, rx_par = 0, par_chk_en = 0, rd_clr = 0;
    logic [7:0] rx_data = '0, tx_data = '0;
    logic [4:0] int_mask = '0;
    logic tx_par, irq;
    logic [4:0] status;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    scsi_evt_status #(.ID_W(ID_W), .DATA_W(8)) i_scsi_evt_status (
        .clk(clk), .rst_n(rst_n),
        .sel_det(sel_det), .sel_id(sel_id), .sel_resp_en(sel_resp_en),
        .resel_det(resel_det), .resel_id(resel_id), .resel_resp_en(resel_resp_en),
        .own_id(own_id), .mode(mode),
        .disc_det(disc_det), .disc_expected(disc_expected), .sel_timeout(sel_timeout),
        .bus_rst(bus_rst),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_par(rx_par), .par_chk_en(par_chk_en),
        .tx_data(tx_data), .tx_par(tx_par),
        .rd_clr(rd_clr), .int_mask(int_mask), .status(status), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic idle();
        sel_det = 0; resel_det = 0; disc_det = 0; disc_expected = 0;
        sel_timeout = 0; rx_valid = 0; rd_clr = 0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R8 reset status", {27'd0, status}, 32'd0);
        chk("R8 reset irq", {31'd0, irq}, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            mode = VEC[i].mode; sel_det = VEC[i].sel; resel_det = VEC[i].resel;
            sel_id = VEC[i].id; resel_id = VEC[i].id;
            sel_resp_en = VEC[i].sel_en; resel_resp_en = VEC[i].resel_en;
            disc_det = VEC[i].disc; disc_expected = VEC[i].disc_exp;
            sel_timeout = VEC[i].sto; rx_valid = VEC[i].rxv; rx_data = VEC[i].rxd;
            rx_par = VEC[i].rxp; par_chk_en = VEC[i].pchk;
            rd_clr = 1'b1;
            @(negedge clk);
            chk($sformatf("R1-7 vector %0d", i), {27'd0, status}, {27'd0, VEC[i].exp});
            idle();
        end

        // R8: sticky without read, then clear
        @(negedge clk);
        rd_clr = 1; @(negedge clk); rd_clr = 0;
        mode = 2'd0; sel_id = 3'd5; sel_resp_en = 1; sel_det = 1;
        @(negedge clk); sel_det = 0;
        repeat (3) @(negedge clk);
        chk("R8 sticky", {27'd0, status}, 32'h1);
        rd_clr = 1; @(negedge clk); rd_clr = 0;
        chk("R8 cleared", {27'd0, status}, 32'h0);

        // R6: held reset gives one event
        bus_rst = 1;
        @(negedge clk);
        chk("R6 rising edge", {31'd0, status[3]}, 32'h1);
        rd_clr = 1; @(negedge clk); rd_clr = 0;
        chk("R6 clear while held", {31'd0, status[3]}, 32'h0);
        repeat (4) @(negedge clk);
        chk("R6 no repeat while held", {31'd0, status[3]}, 32'h0);
        bus_rst = 0; @(negedge clk);
        chk("R6 falling edge ignored", {31'd0, status[3]}, 32'h0);
        bus_rst = 1; @(negedge clk); bus_rst = 0;
        chk("R6 new edge", {31'd0, status[3]}, 32'h1);
        rd_clr = 1; @(negedge clk); rd_clr = 0;

        // R9: interrupt masking
        sel_det = 1; @(negedge clk); sel_det = 0;
        int_mask = 5'b11110; #1;
        chk("R9 masked", {31'd0, irq}, 32'h0);
        int_mask = 5'b00001; #1;
        chk("R9 unmasked", {31'd0, irq}, 32'h1);
        int_mask = 5'b00000;

        // R10: transmit parity independent of check enable
        par_chk_en = 0; tx_data = 8'h00; #1;
        chk("R10 tx 00", {31'd0, tx_par}, 32'h1);
        tx_data = 8'h07; #1;
        chk("R10 tx 07", {31'd0, tx_par}, 32'h0);
        par_chk_en = 1; tx_data = 8'hA5; #1;
        chk("R10 tx A5", {31'd0, tx_par}, 32'h1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule